// File: doc/BRIEF.md
# Ethernet MAC Configuration and Status Register Block

This block holds the software-visible configuration of a simple Ethernet MAC. A 32-bit, word-addressed bus port reads and writes a set of control registers: operating mode, interrupt flags and their enables, transmit and receive inter-frame gaps, frame length limits, collision settings, the number of transmit descriptors, management-port registers, a 48-bit station address split over two words, and a 64-bit multicast hash filter. The same port also opens a window onto a descriptor RAM. The transmit and receive engines read that RAM through a separate read port.

The stored values drive the transmit and receive engines directly as outputs. The engines raise interrupt events on per-bit set strobes. Software clears those events by writing ones to the flag register. A single interrupt line combines the enabled flags.

Writes to the descriptor-count register also reload the receive descriptor ring index. Writing the mode register with its soft-reset bit set returns every register to its reset value.

Top module: `mac_regfile`

## Requirements
- R1: After reset the registers read: mode 0x0000A000, transmit gap 0x12, receive gap one 0x0C, receive gap two 0x12, frame length 0x003C0600, collision settings 0x000F003F, management mode 0x64, descriptor count 0x80, receive ring index 0x80. Every other register reads 0.
- R2: The register byte offsets are as follows:
  - mode 0x00
  - interrupt flags 0x04
  - interrupt enable 0x08
  - station low 0x0C
  - station high 0x10
  - hash low 0x14
  - hash high 0x18
  - transmit gap 0x1C
  - receive gap one 0x20
  - receive gap two 0x24
  - frame length 0x28
  - collision 0x2C
  - descriptor count 0x30
  - management mode 0x34
  - management command 0x38
  - management address 0x3C
  - management write data 0x40
  - management read data 0x44
  - management status 0x48
- R3: Read data appears on `bus_rdata` in the cycle after the clock edge that samples `bus_rd`. It holds its value while `bus_rd` is low.
- R4: A write to the interrupt flag register clears each flag whose data bit is 1 and leaves the other flags unchanged.
- R5: Each `irq_set` bit sets its flag at the next clock edge. When an engine sets a flag in the same cycle that a bus write clears it, the flag ends up set.
- R6: `irq_o` is high exactly when some flag is set and its bit in the interrupt enable register is also set.
- R7: A mode write with bit 11 set stores nothing. Instead it returns every register and the receive ring index to the R1 values and clears all flags except those set in the same cycle.
- R8: Station low holds address bytes 3..0, with byte 3 in bits 31:24. Station high keeps only bits 15:0, with byte 5 in bits 15:8 and byte 4 in bits 7:0. `station_addr_o` carries byte 5 in bits 47:40 down to byte 0 in bits 7:0.
- R9: A write to the descriptor count register keeps only data bits 7:0. The same edge loads those 8 bits into `rx_ring_idx_o`.
- R10: Byte offsets 0x400 to 0x5FF address a 128-word descriptor RAM at word (offset - 0x400)/4 for both reads and writes. `eng_desc_word` shows the word selected by `eng_desc_idx` combinationally.
- R11: Accesses with offset bits 1:0 not equal to 00 change no state, and reads of such offsets return 0.
- R12: Aligned offsets outside the registers and the window read 0, and writes to them change no state.
- R13: `min_frame_o` is frame length bits 31:16 and `max_frame_o` is bits 15:0. `hash_filter_o` is {hash high, hash low}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 11 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_set | input | 7 | Per-flag set strobes from the engines |
| irq_o | output | 1 | Combined interrupt request |
| mode_o | output | 32 | Mode register |
| ipg_tx_o | output | 32 | Transmit inter-frame gap |
| ipg_rx1_o | output | 32 | Receive inter-frame gap, part one |
| ipg_rx2_o | output | 32 | Receive inter-frame gap, part two |
| min_frame_o | output | 16 | Minimum frame length |
| max_frame_o | output | 16 | Maximum frame length |
| coll_cfg_o | output | 32 | Collision settings |
| txd_count_o | output | 8 | Transmit descriptor count |
| rx_ring_idx_o | output | 8 | Receive descriptor ring index |
| station_addr_o | output | 48 | Station address, byte 5 at the top |
| hash_filter_o | output | 64 | Multicast hash filter |
| mgmt_mode_o | output | 32 | Management port mode |
| mgmt_cmd_o | output | 32 | Management port command |
| mgmt_addr_o | output | 32 | Management port address |
| mgmt_wdata_o | output | 32 | Management port write data |
| eng_desc_idx | input | 7 | Engine descriptor word index |
| eng_desc_word | output | 32 | Descriptor word at that index |

## Verification
The assertions assume that the bus never issues two writes in one cycle, so each write touches at most one register. They also assume that `irq_set` is held at zero during a flag-clearing write whenever the clear itself is under check. The bench drives every input on the falling edge and issues one bus operation at a time. It keeps `irq_set` quiet during bus traffic, except for the single directed cycle that tests a set colliding with a clear. Random stimulus covers mapped, windowed, misaligned and unmapped offsets, including occasional soft-reset writes. The bench model applies the same rules as the requirements and compares every read and every engine-facing output against them.

// File: rtl/mac_regs_pkg.sv
package mac_regs_pkg;

  localparam int NREG     = 19;
  localparam int SRST_BIT = 11;

  typedef enum logic [4:0] {
    SEL_MODE       = 5'd0,
    SEL_IRQ_FLAGS  = 5'd1,
    SEL_IRQ_EN     = 5'd2,
    SEL_STA_LO     = 5'd3,
    SEL_STA_HI     = 5'd4,
    SEL_HASH_LO    = 5'd5,
    SEL_HASH_HI    = 5'd6,
    SEL_IPG_TX     = 5'd7,
    SEL_IPG_RX1    = 5'd8,
    SEL_IPG_RX2    = 5'd9,
    SEL_FRAME_LEN  = 5'd10,
    SEL_COLL       = 5'd11,
    SEL_TXD_CNT    = 5'd12,
    SEL_MGMT_MODE  = 5'd13,
    SEL_MGMT_CMD   = 5'd14,
    SEL_MGMT_ADDR  = 5'd15,
    SEL_MGMT_WDATA = 5'd16,
    SEL_MGMT_RDATA = 5'd17,
    SEL_MGMT_STAT  = 5'd18,
    SEL_DESC       = 5'd30,
    SEL_NONE       = 5'd31
  } reg_sel_e;

  // Value each register takes at reset and at soft reset.
  function automatic logic [31:0] reg_default(input reg_sel_e s);
    case (s)
      SEL_MODE:      reg_default = 32'h0000_A000;
      SEL_IPG_TX:    reg_default = 32'h0000_0012;
      SEL_IPG_RX1:   reg_default = 32'h0000_000C;
      SEL_IPG_RX2:   reg_default = 32'h0000_0012;
      SEL_FRAME_LEN: reg_default = 32'h003C_0600;
      SEL_COLL:      reg_default = 32'h000F_003F;
      SEL_TXD_CNT:   reg_default = 32'h0000_0080;
      SEL_MGMT_MODE: reg_default = 32'h0000_0064;
      default:       reg_default = 32'h0000_0000;
    endcase
  endfunction

  // Bits a bus write may store.
  function automatic logic [31:0] reg_wmask(input reg_sel_e s);
    case (s)
      SEL_STA_HI:  reg_wmask = 32'h0000_FFFF;
      SEL_TXD_CNT: reg_wmask = 32'h0000_00FF;
      default:     reg_wmask = 32'hFFFF_FFFF;
    endcase
  endfunction

  // Flag update: clear written ones, then OR in engine sets (set wins).
  function automatic logic [31:0] flag_next(input logic [31:0] cur,
                                            input logic [31:0] clr,
                                            input logic [31:0] set);
    flag_next = (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/mac_addr_decode.sv
module mac_addr_decode
  import mac_regs_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int DESC_BASE  = 'h400,
  parameter int DESC_WORDS = 128,
  localparam int DESC_AW   = $clog2(DESC_WORDS)
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic               aligned,
  output reg_sel_e           sel,
  output logic [DESC_AW-1:0] desc_idx
);

  localparam logic [31:0] WIN_LO = 32'(DESC_BASE);
  localparam logic [31:0] WIN_HI = 32'(DESC_BASE + DESC_WORDS * 4);

  logic [31:0]       a32;
  logic [ADDR_W-3:0] word;
  logic              in_win;

  assign a32      = 32'(addr);
  assign word     = addr[ADDR_W-1:2];
  assign aligned  = (addr[1:0] == 2'b00);
  assign in_win   = (a32 >= WIN_LO) && (a32 < WIN_HI);
  assign desc_idx = DESC_AW'((a32 - WIN_LO) >> 2);

  always_comb begin
    if (!aligned)                   sel = SEL_NONE;
    else if (32'(word) < NREG)      sel = reg_sel_e'(word[4:0]);
    else if (in_win)                sel = SEL_DESC;
    else                            sel = SEL_NONE;
  end

endmodule

// File: rtl/mac_irq_flags.sv
module mac_irq_flags
  import mac_regs_pkg::*;
#(
  parameter int IRQ_BITS = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst,
  input  logic                clr_en,
  input  logic [IRQ_BITS-1:0] clr_mask,
  input  logic [IRQ_BITS-1:0] set_req,
  output logic [IRQ_BITS-1:0] flags_q
);

  logic [31:0] upd;

  assign upd = flag_next(32'(flags_q), clr_en ? 32'(clr_mask) : 32'd0, 32'(set_req));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= '0;
    else if (soft_rst) flags_q <= set_req;
    else               flags_q <= upd[IRQ_BITS-1:0];
  end

endmodule

// File: rtl/mac_desc_ram.sv
module mac_desc_ram #(
  parameter int WORDS = 128,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] bus_idx,
  input  logic [31:0]   wdata,
  output logic [31:0]   bus_word,
  input  logic [AW-1:0] eng_idx,
  output logic [31:0]   eng_word
);

  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[bus_idx] <= wdata;
  end

  assign bus_word = mem[bus_idx];
  assign eng_word = mem[eng_idx];

endmodule

// File: rtl/mac_regfile.sv
module mac_regfile
  import mac_regs_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int IRQ_BITS   = 7,
  parameter int DESC_BASE  = 'h400,
  parameter int DESC_WORDS = 128,
  localparam int DESC_AW   = $clog2(DESC_WORDS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [IRQ_BITS-1:0] irq_set,
  output logic                irq_o,
  output logic [31:0]         mode_o,
  output logic [31:0]         ipg_tx_o,
  output logic [31:0]         ipg_rx1_o,
  output logic [31:0]         ipg_rx2_o,
  output logic [15:0]         min_frame_o,
  output logic [15:0]         max_frame_o,
  output logic [31:0]         coll_cfg_o,
  output logic [7:0]          txd_count_o,
  output logic [7:0]          rx_ring_idx_o,
  output logic [47:0]         station_addr_o,
  output logic [63:0]         hash_filter_o,
  output logic [31:0]         mgmt_mode_o,
  output logic [31:0]         mgmt_cmd_o,
  output logic [31:0]         mgmt_addr_o,
  output logic [31:0]         mgmt_wdata_o,
  input  logic [DESC_AW-1:0]  eng_desc_idx,
  output logic [31:0]         eng_desc_word
);

  localparam logic [31:0] TXD_DEF = reg_default(SEL_TXD_CNT);

  // Decode
  logic               aligned;
  reg_sel_e           sel;
  logic [DESC_AW-1:0] desc_idx;

  mac_addr_decode #(
    .ADDR_W(ADDR_W), .DESC_BASE(DESC_BASE), .DESC_WORDS(DESC_WORDS)
  ) u_dec (
    .addr(bus_addr), .aligned(aligned), .sel(sel), .desc_idx(desc_idx)
  );

  // Named internal events
  logic wr_hit, soft_rst, flags_clr_hit, txd_wr_hit, desc_we;
  assign wr_hit        = bus_wr && aligned;
  assign soft_rst      = wr_hit && (sel == SEL_MODE) && bus_wdata[SRST_BIT];
  assign flags_clr_hit = wr_hit && (sel == SEL_IRQ_FLAGS);
  assign txd_wr_hit    = wr_hit && (sel == SEL_TXD_CNT);
  assign desc_we       = wr_hit && (sel == SEL_DESC);

  // Interrupt flags
  logic [IRQ_BITS-1:0] irq_flags_q;

  mac_irq_flags #(.IRQ_BITS(IRQ_BITS)) u_irq (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .clr_en(flags_clr_hit), .clr_mask(bus_wdata[IRQ_BITS-1:0]),
    .set_req(irq_set), .flags_q(irq_flags_q)
  );

  // Plain storage registers, one per map slot
  logic [NREG-1:0][31:0] regs_w;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == int'(SEL_IRQ_FLAGS)) begin : g_flags
      assign regs_w[g] = 32'(irq_flags_q);
    end else begin : g_store
      logic [31:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          q <= reg_default(reg_sel_e'(g));
        else if (soft_rst)
          q <= reg_default(reg_sel_e'(g));
        else if (wr_hit && (sel == reg_sel_e'(g)))
          q <= bus_wdata & reg_wmask(reg_sel_e'(g));
      end
      assign regs_w[g] = q;
    end
  end

  // Receive ring index: reloaded by descriptor-count writes
  logic [7:0] rx_idx_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rx_idx_q <= TXD_DEF[7:0];
    else if (soft_rst)   rx_idx_q <= TXD_DEF[7:0];
    else if (txd_wr_hit) rx_idx_q <= bus_wdata[7:0];
  end

  // Descriptor RAM
  logic [31:0] desc_bus_word;
  mac_desc_ram #(.WORDS(DESC_WORDS)) u_ram (
    .clk(clk), .we(desc_we), .bus_idx(desc_idx), .wdata(bus_wdata),
    .bus_word(desc_bus_word), .eng_idx(eng_desc_idx), .eng_word(eng_desc_word)
  );

  // Read path
  logic [31:0] rd_val;
  always_comb begin
    case (sel)
      SEL_DESC: rd_val = desc_bus_word;
      SEL_NONE: rd_val = 32'd0;
      default:  rd_val = regs_w[sel];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= 32'd0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  // Engine-facing outputs
  logic [31:0] irq_en_w, frame_w;
  assign irq_en_w       = regs_w[SEL_IRQ_EN];
  assign frame_w        = regs_w[SEL_FRAME_LEN];
  assign irq_o          = |(irq_flags_q & irq_en_w[IRQ_BITS-1:0]);
  assign mode_o         = regs_w[SEL_MODE];
  assign ipg_tx_o       = regs_w[SEL_IPG_TX];
  assign ipg_rx1_o      = regs_w[SEL_IPG_RX1];
  assign ipg_rx2_o      = regs_w[SEL_IPG_RX2];
  assign min_frame_o    = frame_w[31:16];
  assign max_frame_o    = frame_w[15:0];
  assign coll_cfg_o     = regs_w[SEL_COLL];
  assign txd_count_o    = regs_w[SEL_TXD_CNT][7:0];
  assign rx_ring_idx_o  = rx_idx_q;
  assign station_addr_o = {regs_w[SEL_STA_HI][15:0], regs_w[SEL_STA_LO]};
  assign hash_filter_o  = {regs_w[SEL_HASH_HI], regs_w[SEL_HASH_LO]};
  assign mgmt_mode_o    = regs_w[SEL_MGMT_MODE];
  assign mgmt_cmd_o     = regs_w[SEL_MGMT_CMD];
  assign mgmt_addr_o    = regs_w[SEL_MGMT_ADDR];
  assign mgmt_wdata_o   = regs_w[SEL_MGMT_WDATA];

endmodule

// File: rtl/mac_regfile_chk.sv
module mac_regfile_chk #(
  parameter int ADDR_W   = 11,
  parameter int IRQ_BITS = 7
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [31:0]         bus_wdata,
  input logic [31:0]         bus_rdata,
  input logic [IRQ_BITS-1:0] irq_set,
  input logic [IRQ_BITS-1:0] irq_flags_q,
  input logic                flags_clr_hit,
  input logic                txd_wr_hit,
  input logic                soft_rst,
  input logic [31:0]         mode_o,
  input logic [15:0]         min_frame_o,
  input logic [15:0]         max_frame_o,
  input logic [7:0]          txd_count_o,
  input logic [7:0]          rx_ring_idx_o,
  input logic [47:0]         station_addr_o,
  input logic [63:0]         hash_filter_o
);

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R3

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_clr_hit && irq_set == '0) |=> ((irq_flags_q & $past(bus_wdata[IRQ_BITS-1:0])) == '0)); // R4

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_set) |=> ((irq_flags_q & $past(irq_set)) == $past(irq_set))); // R5

  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (mode_o == 32'h0000_A000 && txd_count_o == 8'h80 && rx_ring_idx_o == 8'h80
                  && min_frame_o == 16'd60 && max_frame_o == 16'd1536
                  && station_addr_o == 48'd0 && hash_filter_o == 64'd0)); // R7

  AST_TXD_LOADS_RING: assert property (@(posedge clk) disable iff (!rst_n)
    txd_wr_hit |=> (rx_ring_idx_o == $past(bus_wdata[7:0]) && txd_count_o == $past(bus_wdata[7:0]))); // R9

  AST_MISALIGNED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[1:0] != 2'b00) |=> ($stable(mode_o) && $stable(station_addr_o)
      && $stable(hash_filter_o) && $stable(txd_count_o) && $stable(rx_ring_idx_o))); // R11

  AST_MISALIGNED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[1:0] != 2'b00) |=> (bus_rdata == 32'd0)); // R11

endmodule

bind mac_regfile mac_regfile_chk #(.ADDR_W(ADDR_W), .IRQ_BITS(IRQ_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_set(irq_set),
  .irq_flags_q(irq_flags_q), .flags_clr_hit(flags_clr_hit), .txd_wr_hit(txd_wr_hit),
  .soft_rst(soft_rst), .mode_o(mode_o), .min_frame_o(min_frame_o),
  .max_frame_o(max_frame_o), .txd_count_o(txd_count_o), .rx_ring_idx_o(rx_ring_idx_o),
  .station_addr_o(station_addr_o), .hash_filter_o(hash_filter_o)
);

// File: tb/test_mac_regfile.sv
`timescale 1ns/1ps
module test_mac_regfile;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [6:0]  irq_set = '0;
  logic        irq_o;
  logic [31:0] mode_o, ipg_tx_o, ipg_rx1_o, ipg_rx2_o, coll_cfg_o;
  logic [15:0] min_frame_o, max_frame_o;
  logic [7:0]  txd_count_o, rx_ring_idx_o;
  logic [47:0] station_addr_o;
  logic [63:0] hash_filter_o;
  logic [31:0] mgmt_mode_o, mgmt_cmd_o, mgmt_addr_o, mgmt_wdata_o;
  logic [6:0]  eng_desc_idx = '0;
  logic [31:0] eng_desc_word;

  always #4 clk = ~clk;

  mac_regfile i_mac_regfile (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_set(irq_set), .irq_o(irq_o),
    .mode_o(mode_o), .ipg_tx_o(ipg_tx_o), .ipg_rx1_o(ipg_rx1_o), .ipg_rx2_o(ipg_rx2_o),
    .min_frame_o(min_frame_o), .max_frame_o(max_frame_o), .coll_cfg_o(coll_cfg_o),
    .txd_count_o(txd_count_o), .rx_ring_idx_o(rx_ring_idx_o),
    .station_addr_o(station_addr_o), .hash_filter_o(hash_filter_o),
    .mgmt_mode_o(mgmt_mode_o), .mgmt_cmd_o(mgmt_cmd_o), .mgmt_addr_o(mgmt_addr_o),
    .mgmt_wdata_o(mgmt_wdata_o), .eng_desc_idx(eng_desc_idx), .eng_desc_word(eng_desc_word)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  // Model state
  logic [31:0] m_reg [19];
  logic [6:0]  m_flags;
  logic [7:0]  m_ring;
  logic [31:0] m_ram [128];
  bit          m_ram_ok [128];

  function automatic logic [31:0] dflt(input int i);
    case (i)
      0:  return 32'h0000_A000;
      7:  return 32'h12;
      8:  return 32'h0C;
      9:  return 32'h12;
      10: return 32'h003C_0600;
      11: return 32'h000F_003F;
      12: return 32'h80;
      13: return 32'h64;
      default: return 32'h0;
    endcase
  endfunction

  task automatic m_defaults();
    for (int i = 0; i < 19; i++) m_reg[i] = dflt(i);
    m_flags = '0;
    m_ring  = 8'h80;
  endtask

  task automatic m_write(input logic [10:0] a, input logic [31:0] d);
    int w;
    if (a[1:0] != 2'b00) return;
    w = int'(a) / 4;
    if (w < 19) begin
      case (w)
        0:  if (d[11]) m_defaults(); else m_reg[0] = d;
        1:  m_flags = m_flags & ~d[6:0];
        4:  m_reg[4] = d & 32'hFFFF;
        12: begin m_reg[12] = d & 32'hFF; m_ring = d[7:0]; end
        default: m_reg[w] = d;
      endcase
    end else if (a >= 11'h400 && a < 11'h600) begin
      m_ram[(int'(a) - 'h400) / 4] = d;
      m_ram_ok[(int'(a) - 'h400) / 4] = 1'b1;
    end
  endtask

  function automatic logic [31:0] m_read(input logic [10:0] a, output bit known);
    int w;
    known = 1'b1;
    if (a[1:0] != 2'b00) return 32'h0;
    w = int'(a) / 4;
    if (w == 1) return 32'(m_flags);
    if (w < 19) return m_reg[w];
    if (a >= 11'h400 && a < 11'h600) begin
      known = m_ram_ok[(int'(a) - 'h400) / 4];
      return m_ram[(int'(a) - 'h400) / 4];
    end
    return 32'h0;
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [10:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    m_write(a, d);
  endtask

  task automatic bus_read(input logic [10:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic read_check(input string req, input logic [10:0] a);
    logic [31:0] got, exp;
    bit known;
    bus_read(a, got);
    exp = m_read(a, known);
    if (known) check(req, 64'(got), 64'(exp));
  endtask

  task automatic outputs_check(input string tag);
    check({tag, " R1 mode_o"}, 64'(mode_o), 64'(m_reg[0]));
    check({tag, " R6 irq_o"}, 64'(irq_o), 64'(|(m_flags & m_reg[2][6:0])));
    check({tag, " R8 station"}, 64'(station_addr_o), 64'({m_reg[4][15:0], m_reg[3]}));
    check({tag, " R9 ring"}, 64'({txd_count_o, rx_ring_idx_o}), 64'({m_reg[12][7:0], m_ring}));
    check({tag, " R13 frame"}, 64'({min_frame_o, max_frame_o}), 64'(m_reg[10]));
    check({tag, " R13 hash"}, hash_filter_o, {m_reg[6], m_reg[5]});
  endtask

  // Watchdog
  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, hold;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 128; i++) m_ram_ok[i] = 1'b0;
    m_defaults();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1, R2: reset values at every mapped offset
    check("R3 rdata after reset", 64'(bus_rdata), 64'd0);
    for (int i = 0; i < 19; i++) read_check("R1 R2 reset read", 11'(i * 4));
    outputs_check("reset");
    check("R1 ipg outputs", 64'({ipg_tx_o, ipg_rx1_o}), 64'({32'h12, 32'h0C}));
    check("R1 coll/mgmt", 64'({coll_cfg_o, mgmt_mode_o}), 64'({32'h000F003F, 32'h64}));

    // R8 station address layout
    bus_write(11'h00C, 32'h3322_1100);
    bus_write(11'h010, 32'hABCD_5544);
    check("R8 station packing", 64'(station_addr_o), 64'(48'h5544_3322_1100));
    read_check("R8 station high masked", 11'h010);

    // R9 descriptor count
    bus_write(11'h030, 32'h1234_56C3);
    check("R9 ring loaded", 64'(rx_ring_idx_o), 64'h00C3);
    read_check("R9 count low byte", 11'h030);

    // R5, R4, R6 interrupt flags
    @(negedge clk); irq_set = 7'h15;
    @(negedge clk); irq_set = 7'h00; m_flags |= 7'h15;
    read_check("R5 flags set", 11'h004);
    bus_write(11'h008, 32'h0000_0004);
    check("R6 irq asserted", 64'(irq_o), 64'd1);
    bus_write(11'h004, 32'h0000_0004);
    read_check("R4 w1c", 11'h004);
    check("R6 irq dropped", 64'(irq_o), 64'd0);
    @(negedge clk);
    bus_addr = 11'h004; bus_wdata = 32'h1; bus_wr = 1'b1; irq_set = 7'h01;
    @(negedge clk);
    bus_wr = 1'b0; irq_set = 7'h00;
    m_flags = (m_flags & ~7'h01) | 7'h01;
    read_check("R5 set beats clear", 11'h004);

    // R7 soft reset
    bus_write(11'h014, 32'hDEAD_BEEF);
    bus_write(11'h000, 32'h0000_0800);
    outputs_check("R7 soft reset");
    read_check("R7 flags cleared", 11'h004);
    read_check("R7 hash cleared", 11'h014);

    // R10 descriptor window
    bus_write(11'h414, 32'hCAFE_0005);
    bus_write(11'h5FC, 32'h0BAD_F00D);
    read_check("R10 window word 5", 11'h414);
    read_check("R10 window last word", 11'h5FC);
    eng_desc_idx = 7'd5;
    #1 check("R10 engine port", 64'(eng_desc_word), 64'h00000000CAFE0005);
    eng_desc_idx = 7'd127;
    #1 check("R10 engine last", 64'(eng_desc_word), 64'h000000000BADF00D);

    // R12 unmapped
    bus_write(11'h600, 32'hFFFF_FFFF);
    read_check("R12 past window", 11'h600);
    bus_write(11'h04C, 32'hFFFF_FFFF);
    read_check("R12 gap offset", 11'h04C);
    outputs_check("R12 no effect");

    // R11 misaligned
    bus_write(11'h001, 32'h0000_0FFF);
    bus_write(11'h416, 32'h1111_1111);
    outputs_check("R11 misaligned write");
    read_check("R11 window untouched", 11'h414);
    read_check("R11 misaligned read", 11'h415);

    // R3 read data holds with no strobe
    bus_read(11'h028, hold);
    @(negedge clk); bus_addr = 11'h01C;
    @(negedge clk);
    check("R3 rdata holds", 64'(bus_rdata), 64'(hold));

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int cat;
      logic [10:0] a;
      logic [31:0] d;
      cat = int'($urandom % 100);
      if (cat < 60)      a = 11'(($urandom % 19) * 4);
      else if (cat < 85) a = 11'('h400 + ($urandom % 128) * 4);
      else if (cat < 93) a = 11'(($urandom % 2048) | 1);
      else               a = 11'('h04C + ($urandom % 189) * 4);
      d = $urandom;
      if (a == 11'h000) d[11] = (($urandom % 8) == 0);
      if ($urandom % 2) bus_write(a, d);
      else read_check("R2 R10 R11 R12 random read", a);
      outputs_check("random");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule